// File: doc/BRIEF.md
# Word-to-Byte SPI Data Queue Adapter

This block connects a 32-bit register port to two byte-wide queues that serve a SPI shift engine. On the transmit side, one register write is cut into four bytes, lowest byte first, and all of them go into a 288-entry byte queue in a single clock. The shift engine then drains that queue one byte at a time through a valid/ready handshake. On the receive side, the engine pushes bytes into a 256-entry queue through the same kind of handshake. A register read then removes up to four of those bytes in one clock and packs them into a word, with the oldest byte in the low lane.

Software sees the occupancy of each queue as a count of 32-bit words, rounded up, and four flags: empty and full for each direction. A word write that does not fit is accepted only in part and raises a one-cycle overflow pulse. A read of an empty receive queue raises a one-cycle underflow pulse and returns zero. A synchronous software reset empties both queues in one cycle. The shift engine itself is outside this block.

Top module: `spi_wb_adapter`

## Requirements
- R1: A TX write stores bytes 7:0, 15:8, 23:16 and 31:24 of the word in that order. The engine receives them on `tx_byte_data` in the same order.
- R2: When fewer than four TX entries are free, only the free count of bytes is stored, starting from the lowest byte, and the rest are dropped. `overflow_err` is high in the cycle after such a write.
- R3: An RX read removes min(4, stored bytes). The first byte removed appears in bits 7:0, the next in 15:8 and so on. Unfilled lanes read zero. The word appears on `rx_rd_data` in the cycle after the read and holds until the next read.
- R4: An RX read of an empty queue returns zero and leaves the queue empty. `underflow_err` is high in the cycle after the read.
- R5: `tx_depth_words` and `rx_depth_words` equal the stored byte count plus three, divided by four (rounded up), one cycle after any change.
- R6: Each empty flag is 1 exactly when its queue holds no bytes. Each full flag is 1 exactly when its queue holds its capacity.
- R7: `tx_byte_valid` is high whenever the TX queue holds a byte, and a byte is removed on valid and ready together. `rx_byte_ready` is high whenever the RX queue is not full, and a byte is stored on valid and ready together.
- R8: `sw_reset` empties both queues in one cycle. In the next cycle both empty flags are 1, both full flags and both error pulses are 0, and `rx_rd_data` is zero. Requests made in the reset cycle are dropped.
- R9: Each error pulse lasts one cycle per offending request. A fully accepted write or a read of a non-empty queue gives no pulse.
- R10: The TX queue holds exactly 288 bytes (72 whole words accepted without overflow). The RX queue holds exactly 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_reset | input | 1 | Synchronous flush of both queues |
| tx_wr_en | input | 1 | TX data word write strobe |
| tx_wr_data | input | 32 | TX data word |
| rx_rd_en | input | 1 | RX data word read strobe |
| rx_rd_data | output | 32 | Packed RX word, valid the cycle after a read |
| tx_byte_valid | output | 1 | TX queue holds a byte for the engine |
| tx_byte_data | output | 8 | Oldest TX byte |
| tx_byte_ready | input | 1 | Engine takes the TX byte |
| rx_byte_valid | input | 1 | Engine offers an RX byte |
| rx_byte_data | input | 8 | RX byte from the engine |
| rx_byte_ready | output | 1 | RX queue can take a byte |
| tx_depth_words | output | 7 | TX occupancy in words, rounded up |
| rx_depth_words | output | 7 | RX occupancy in words, rounded up |
| tx_full | output | 1 | TX queue at capacity |
| tx_empty | output | 1 | TX queue holds nothing |
| rx_full | output | 1 | RX queue at capacity |
| rx_empty | output | 1 | RX queue holds nothing |
| overflow_err | output | 1 | One-cycle pulse after a write that did not fit |
| underflow_err | output | 1 | One-cycle pulse after a read of an empty RX queue |

## Verification
Every result is due exactly one cycle after the rising edge that takes the request: the flags, the word depths, the engine handshake outputs, the packed read word and both error pulses. Nothing reaches an output combinationally from an input. The bench drives inputs on the falling edge and advances a queue-based model on the rising edge. It compares every output against that model on each following falling edge, so each result is sampled in the cycle it becomes due. Directed checks after each write, read or flush also sample at that falling edge.

// File: rtl/spi_wb_pkg.sv
package spi_wb_pkg;

    localparam int unsigned LANES = 4;

    typedef logic [7:0] byte_t;
    typedef logic [LANES*8-1:0] word_t;

endpackage

// File: rtl/spi_wb_byte_fifo.sv
// Circular byte store that takes up to WR_LANES bytes and releases up to
// RD_LANES bytes per clock.
module spi_wb_byte_fifo
    import spi_wb_pkg::*;
#(
    parameter int DEPTH    = 288,
    parameter int WR_LANES = 4,
    parameter int RD_LANES = 1,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int PC_W    = $clog2(WR_LANES + 1),
    localparam int QC_W    = $clog2(RD_LANES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic [PC_W-1:0]          push_cnt,
    input  byte_t [WR_LANES-1:0]     push_data,
    input  logic [QC_W-1:0]          pop_cnt,
    output byte_t [RD_LANES-1:0]     head,
    output logic [CNT_W-1:0]         count
);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [CNT_W-1:0] count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    byte_t       mem [DEPTH];

    logic [PTR_W-1:0] wr_idx [WR_LANES];
    logic [PTR_W-1:0] rd_idx [RD_LANES];

    function automatic logic [PTR_W-1:0] wrap_idx(input logic [PTR_W:0] raw);
        logic [PTR_W:0] adj;
        adj = (raw >= (PTR_W+1)'(DEPTH)) ? raw - (PTR_W+1)'(DEPTH) : raw;
        return adj[PTR_W-1:0];
    endfunction

    for (genvar g = 0; g < WR_LANES; g++) begin : g_wr_lane
        assign wr_idx[g] = wrap_idx({1'b0, st_q.wr_ptr} + (PTR_W+1)'(g));
    end

    for (genvar g = 0; g < RD_LANES; g++) begin : g_rd_lane
        assign rd_idx[g] = wrap_idx({1'b0, st_q.rd_ptr} + (PTR_W+1)'(g));
        assign head[g]   = mem[rd_idx[g]];
    end

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            st_d.wr_ptr = wrap_idx({1'b0, st_q.wr_ptr} + (PTR_W+1)'(push_cnt));
            st_d.rd_ptr = wrap_idx({1'b0, st_q.rd_ptr} + (PTR_W+1)'(pop_cnt));
            st_d.count  = st_q.count + CNT_W'(push_cnt) - CNT_W'(pop_cnt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!flush) begin
            for (int i = 0; i < WR_LANES; i++) begin
                if (int'(push_cnt) > i) begin
                    mem[wr_idx[i]] <= push_data[i];
                end
            end
        end
    end

    assign count = st_q.count;

    // R10: occupancy never exceeds capacity
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));

    // R7: the caller never removes more bytes than are stored
    a_r7_pop_within_count: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (CNT_W'(pop_cnt) <= st_q.count));

    // R2: the caller never stores more bytes than there is room for
    a_r2_push_within_room: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (CNT_W'(push_cnt) <= CNT_W'(DEPTH) - st_q.count));

endmodule

// File: rtl/spi_wb_tx_split.sv
// Cuts a bus word into byte lanes and limits the count to the free room.
module spi_wb_tx_split
    import spi_wb_pkg::*;
#(
    parameter int CNT_W  = 9,
    localparam int PC_W  = $clog2(LANES + 1)
) (
    input  logic                 wr_en,
    input  word_t                wr_data,
    input  logic [CNT_W-1:0]     free,
    output logic [PC_W-1:0]      push_cnt,
    output byte_t [LANES-1:0]    push_data,
    output logic                 overflow
);

    logic             short_room;
    logic [PC_W-1:0]  fit;

    assign short_room = free < CNT_W'(LANES);
    assign fit        = short_room ? PC_W'(free) : PC_W'(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign push_data[g] = wr_data[8*g +: 8];
    end

    assign push_cnt = wr_en ? fit : '0;
    assign overflow = wr_en && short_room;

endmodule

// File: rtl/spi_wb_rx_pack.sv
// Packs up to LANES head bytes into a word, oldest byte in the low lane.
module spi_wb_rx_pack
    import spi_wb_pkg::*;
#(
    parameter int CNT_W  = 9,
    localparam int QC_W  = $clog2(LANES + 1)
) (
    input  logic                 rd_en,
    input  logic [CNT_W-1:0]     count,
    input  byte_t [LANES-1:0]    head,
    output logic [QC_W-1:0]      pop_cnt,
    output word_t                word,
    output logic                 underflow
);

    logic [QC_W-1:0] avail;

    assign avail = (count >= CNT_W'(LANES)) ? QC_W'(LANES) : QC_W'(count);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word[8*g +: 8] = (int'(avail) > g) ? head[g] : 8'h00;
    end

    assign pop_cnt   = rd_en ? avail : '0;
    assign underflow = rd_en && (count == '0);

endmodule

// File: rtl/spi_wb_adapter.sv
module spi_wb_adapter
    import spi_wb_pkg::*;
#(
    parameter int TX_DEPTH = 288,
    parameter int RX_DEPTH = 256
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  sw_reset,
    input  logic                                  tx_wr_en,
    input  logic [31:0]                           tx_wr_data,
    input  logic                                  rx_rd_en,
    output logic [31:0]                           rx_rd_data,
    output logic                                  tx_byte_valid,
    output logic [7:0]                            tx_byte_data,
    input  logic                                  tx_byte_ready,
    input  logic                                  rx_byte_valid,
    input  logic [7:0]                            rx_byte_data,
    output logic                                  rx_byte_ready,
    output logic [$clog2((TX_DEPTH+3)/4+1)-1:0]   tx_depth_words,
    output logic [$clog2((RX_DEPTH+3)/4+1)-1:0]   rx_depth_words,
    output logic                                  tx_full,
    output logic                                  tx_empty,
    output logic                                  rx_full,
    output logic                                  rx_empty,
    output logic                                  overflow_err,
    output logic                                  underflow_err
);

    localparam int TX_CNT_W = $clog2(TX_DEPTH + 1);
    localparam int RX_CNT_W = $clog2(RX_DEPTH + 1);
    localparam int TXW_W    = $clog2((TX_DEPTH+3)/4 + 1);
    localparam int RXW_W    = $clog2((RX_DEPTH+3)/4 + 1);
    localparam int PC_W     = $clog2(LANES + 1);

    typedef struct packed {
        word_t rd_data;
        logic  ovf;
        logic  udf;
    } adp_state_t;

    adp_state_t st_d, st_q;

    logic [TX_CNT_W-1:0] tx_count, tx_free, tx_round;
    logic [RX_CNT_W-1:0] rx_count, rx_round;
    logic [PC_W-1:0]     tx_push_cnt, rx_pop_cnt;
    byte_t [LANES-1:0]   tx_push_data, rx_head;
    byte_t [0:0]         tx_head;
    word_t               rx_word;
    logic                split_ovf, pack_udf;
    logic                tx_pop, rx_push;

    assign tx_free = TX_CNT_W'(TX_DEPTH) - tx_count;

    spi_wb_tx_split #(.CNT_W(TX_CNT_W)) u_split (
        .wr_en     (tx_wr_en),
        .wr_data   (tx_wr_data),
        .free      (tx_free),
        .push_cnt  (tx_push_cnt),
        .push_data (tx_push_data),
        .overflow  (split_ovf)
    );

    spi_wb_byte_fifo #(.DEPTH(TX_DEPTH), .WR_LANES(LANES), .RD_LANES(1)) u_tx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (sw_reset),
        .push_cnt  (tx_push_cnt),
        .push_data (tx_push_data),
        .pop_cnt   (tx_pop),
        .head      (tx_head),
        .count     (tx_count)
    );

    spi_wb_byte_fifo #(.DEPTH(RX_DEPTH), .WR_LANES(1), .RD_LANES(LANES)) u_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (sw_reset),
        .push_cnt  (rx_push),
        .push_data (rx_byte_data),
        .pop_cnt   (rx_pop_cnt),
        .head      (rx_head),
        .count     (rx_count)
    );

    spi_wb_rx_pack #(.CNT_W(RX_CNT_W)) u_pack (
        .rd_en     (rx_rd_en),
        .count     (rx_count),
        .head      (rx_head),
        .pop_cnt   (rx_pop_cnt),
        .word      (rx_word),
        .underflow (pack_udf)
    );

    assign tx_empty      = (tx_count == '0);
    assign tx_full       = (tx_count == TX_CNT_W'(TX_DEPTH));
    assign rx_empty      = (rx_count == '0);
    assign rx_full       = (rx_count == RX_CNT_W'(RX_DEPTH));

    assign tx_byte_valid = !tx_empty;
    assign tx_byte_data  = tx_head[0];
    assign tx_pop        = tx_byte_valid && tx_byte_ready;
    assign rx_byte_ready = !rx_full;
    assign rx_push       = rx_byte_valid && rx_byte_ready;

    assign tx_round       = (tx_count + TX_CNT_W'(3)) >> 2;
    assign rx_round       = (rx_count + RX_CNT_W'(3)) >> 2;
    assign tx_depth_words = tx_round[TXW_W-1:0];
    assign rx_depth_words = rx_round[RXW_W-1:0];

    always_comb begin
        st_d = st_q;
        if (sw_reset) begin
            st_d.rd_data = '0;
            st_d.ovf     = 1'b0;
            st_d.udf     = 1'b0;
        end else begin
            if (rx_rd_en) begin
                st_d.rd_data = rx_word;
            end
            st_d.ovf = split_ovf;
            st_d.udf = pack_udf;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_rd_data    = st_q.rd_data;
    assign overflow_err  = st_q.ovf;
    assign underflow_err = st_q.udf;

    // R2: an overflow pulse only follows a write outside a flush
    a_r2_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |-> ($past(tx_wr_en) && !$past(sw_reset)));

    // R4: an underflow pulse comes with a zero word after an empty queue
    a_r4_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |-> (rx_rd_data == '0 && $past(rx_empty)));

    // R3: the read word holds between reads
    a_r3_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rx_rd_en) && !$past(sw_reset)) |-> $stable(rx_rd_data));

    // R8: a flush leaves both queues empty and no error pulse
    a_r8_flush_clean: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (tx_empty && rx_empty && !tx_full && !rx_full
                      && !overflow_err && !underflow_err));

endmodule

// File: tb/tb_spi_wb_adapter.sv
module tb_spi_wb_adapter;

    localparam int TXD = 288;
    localparam int RXD = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_reset = 1'b0;
    logic        tx_wr_en = 1'b0;
    logic [31:0] tx_wr_data = '0;
    logic        rx_rd_en = 1'b0;
    logic [31:0] rx_rd_data;
    logic        tx_byte_valid;
    logic [7:0]  tx_byte_data;
    logic        tx_byte_ready = 1'b0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte_data = '0;
    logic        rx_byte_ready;
    logic [6:0]  tx_depth_words, rx_depth_words;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic        overflow_err, underflow_err;

    spi_wb_adapter dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .tx_wr_en(tx_wr_en), .tx_wr_data(tx_wr_data),
        .rx_rd_en(rx_rd_en), .rx_rd_data(rx_rd_data),
        .tx_byte_valid(tx_byte_valid), .tx_byte_data(tx_byte_data),
        .tx_byte_ready(tx_byte_ready),
        .rx_byte_valid(rx_byte_valid), .rx_byte_data(rx_byte_data),
        .rx_byte_ready(rx_byte_ready),
        .tx_depth_words(tx_depth_words), .rx_depth_words(rx_depth_words),
        .tx_full(tx_full), .tx_empty(tx_empty),
        .rx_full(rx_full), .rx_empty(rx_empty),
        .overflow_err(overflow_err), .underflow_err(underflow_err)
    );

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit running  = 1'b0;

    // behavioural reference
    logic [7:0]  txq [$];
    logic [7:0]  rxq [$];
    logic [31:0] m_rd  = '0;
    logic        m_ovf = 1'b0;
    logic        m_udf = 1'b0;
    int          m_txold, m_rxold, m_take;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete(); rxq.delete();
            m_rd = '0; m_ovf = 1'b0; m_udf = 1'b0;
        end else if (sw_reset) begin
            txq.delete(); rxq.delete();
            m_rd = '0; m_ovf = 1'b0; m_udf = 1'b0;
        end else begin
            m_txold = txq.size();
            m_rxold = rxq.size();
            if (m_txold > 0 && tx_byte_ready) void'(txq.pop_front());
            m_ovf = 1'b0;
            if (tx_wr_en) begin
                m_take = (TXD - m_txold < 4) ? TXD - m_txold : 4;
                for (int k = 0; k < m_take; k++) txq.push_back(tx_wr_data[8*k +: 8]);
                m_ovf = (m_take < 4);
            end
            m_udf = 1'b0;
            if (rx_rd_en) begin
                m_take = (m_rxold < 4) ? m_rxold : 4;
                m_rd = '0;
                for (int k = 0; k < m_take; k++) m_rd[8*k +: 8] = rxq.pop_front();
                m_udf = (m_rxold == 0);
            end
            if (rx_byte_valid && m_rxold < RXD) rxq.push_back(rx_byte_data);
        end
    end

    always @(negedge clk) begin
        if (rst_n && running) begin
            chk("R7", "tx_byte_valid", 32'(tx_byte_valid), 32'(txq.size() > 0));
            if (txq.size() > 0) chk("R1", "tx_byte_data", 32'(tx_byte_data), 32'(txq[0]));
            chk("R7", "rx_byte_ready", 32'(rx_byte_ready), 32'(rxq.size() < RXD));
            chk("R3", "rx_rd_data", rx_rd_data, m_rd);
            chk("R2", "overflow_err", 32'(overflow_err), 32'(m_ovf));
            chk("R4", "underflow_err", 32'(underflow_err), 32'(m_udf));
            chk("R5", "tx_depth_words", 32'(tx_depth_words), 32'((txq.size() + 3) / 4));
            chk("R5", "rx_depth_words", 32'(rx_depth_words), 32'((rxq.size() + 3) / 4));
            chk("R6", "flags{txf,txe,rxf,rxe}",
                32'({tx_full, tx_empty, rx_full, rx_empty}),
                32'({txq.size() == TXD, txq.size() == 0, rxq.size() == RXD, rxq.size() == 0}));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] w);
        tx_wr_en = 1'b1; tx_wr_data = w;
        step(1);
        tx_wr_en = 1'b0;
    endtask

    task automatic rd();
        rx_rd_en = 1'b1;
        step(1);
        rx_rd_en = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_byte_valid = 1'b1; rx_byte_data = b;
        step(1);
        rx_byte_valid = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        running = 1'b1;
        step(1);
        chk("R6", "tx_empty after reset", 32'(tx_empty), 32'd1);
        chk("R6", "rx_empty after reset", 32'(rx_empty), 32'd1);
        chk("R5", "tx_depth after reset", 32'(tx_depth_words), 32'd0);

        // byte order and rounding
        wr(32'h44332211);
        chk("R1", "first tx byte", 32'(tx_byte_data), 32'h11);
        chk("R9", "no overflow on fitting write", 32'(overflow_err), 32'd0);
        wr(32'h88776655);
        tx_byte_ready = 1'b1; step(3); tx_byte_ready = 1'b0;
        chk("R5", "5 bytes round up", 32'(tx_depth_words), 32'd2);
        chk("R1", "fourth tx byte", 32'(tx_byte_data), 32'h44);
        tx_byte_ready = 1'b1; step(6); tx_byte_ready = 1'b0;
        chk("R6", "tx drained", 32'(tx_empty), 32'd1);

        // capacity and overflow
        for (int i = 0; i < TXD / 4; i++) wr(32'h01010101 * (i + 1));
        chk("R10", "tx full at 72 words", 32'(tx_full), 32'd1);
        chk("R10", "tx depth 72", 32'(tx_depth_words), 32'd72);
        chk("R10", "no overflow filling", 32'(overflow_err), 32'd0);
        wr(32'hFEEDFACE);
        chk("R2", "overflow on full write", 32'(overflow_err), 32'd1);
        step(1);
        chk("R9", "overflow lasts one cycle", 32'(overflow_err), 32'd0);
        tx_byte_ready = 1'b1; step(2); tx_byte_ready = 1'b0;
        wr(32'hDDCCBBAA);
        chk("R2", "overflow on partial write", 32'(overflow_err), 32'd1);
        chk("R2", "tx full after partial", 32'(tx_full), 32'd1);
        tx_byte_ready = 1'b1; step(TXD + 4); tx_byte_ready = 1'b0;

        // receive packing and underflow
        push_rx(8'hA1); push_rx(8'hA2); push_rx(8'hA3);
        rd();
        chk("R3", "three byte read", rx_rd_data, 32'h00A3A2A1);
        chk("R9", "no underflow on filled read", 32'(underflow_err), 32'd0);
        rd();
        chk("R4", "underflow pulse", 32'(underflow_err), 32'd1);
        chk("R4", "underflow data zero", rx_rd_data, 32'd0);
        chk("R4", "rx still empty", 32'(rx_empty), 32'd1);
        step(1);
        chk("R9", "underflow lasts one cycle", 32'(underflow_err), 32'd0);

        rx_byte_valid = 1'b1;
        for (int i = 0; i < RXD + 4; i++) begin
            rx_byte_data = 8'(i * 7 + 3);
            step(1);
        end
        rx_byte_valid = 1'b0;
        chk("R10", "rx full at 256", 32'(rx_full), 32'd1);
        chk("R7", "rx not ready when full", 32'(rx_byte_ready), 32'd0);
        chk("R10", "rx depth 64", 32'(rx_depth_words), 32'd64);
        rd();
        chk("R3", "first packed word", rx_rd_data, 32'h18110A03);
        for (int i = 0; i < RXD / 4; i++) rd();

        // mixed random traffic
        for (int i = 0; i < 1500; i++) begin
            tx_wr_en      = ($urandom_range(0, 9) < 3);
            tx_wr_data    = $urandom;
            tx_byte_ready = ($urandom_range(0, 9) < 6);
            rx_byte_valid = ($urandom_range(0, 9) < 7);
            rx_byte_data  = 8'($urandom);
            rx_rd_en      = ($urandom_range(0, 9) < 2);
            step(1);
        end
        tx_wr_en = 1'b0; tx_byte_ready = 1'b0; rx_byte_valid = 1'b0; rx_rd_en = 1'b0;
        for (int i = 0; i < 5; i++) begin wr(32'hCAFE0000 + i); push_rx(8'(i)); end

        // flush with competing requests
        sw_reset = 1'b1; tx_wr_en = 1'b1; rx_rd_en = 1'b1; rx_byte_valid = 1'b1;
        step(1);
        sw_reset = 1'b0; tx_wr_en = 1'b0; rx_rd_en = 1'b0; rx_byte_valid = 1'b0;
        chk("R8", "tx empty after flush", 32'(tx_empty), 32'd1);
        chk("R8", "rx empty after flush", 32'(rx_empty), 32'd1);
        chk("R8", "full flags clear", 32'({tx_full, rx_full}), 32'd0);
        chk("R8", "no error pulses", 32'({overflow_err, underflow_err}), 32'd0);
        chk("R8", "read word cleared", rx_rd_data, 32'd0);

        for (int i = 0; i < 300; i++) begin
            tx_wr_en      = ($urandom_range(0, 9) < 5);
            tx_wr_data    = $urandom;
            tx_byte_ready = ($urandom_range(0, 9) < 3);
            rx_byte_valid = ($urandom_range(0, 9) < 5);
            rx_byte_data  = 8'($urandom);
            rx_rd_en      = ($urandom_range(0, 9) < 3);
            step(1);
        end
        tx_wr_en = 1'b0; rx_rd_en = 1'b0; rx_byte_valid = 1'b0; tx_byte_ready = 1'b0;
        step(2);
        running = 1'b0;
        finish_run();
    end

endmodule